// File: doc/BRIEF.md
# DRAM Rank Power-State Controller

This block runs the power-state machine of one DRAM rank. It watches how many banks are open, how many activate, read and write operations are still in flight, and how many reads and writes are queued for the rank. It also watches the direction of the data bus and the request and done strobes of the refresh controller. From these it chooses among six states: idle, refresh, self-refresh, precharge power-down, active and active power-down.

When the rank is quiet and power-down is allowed, the block drops it into the power-down state that matches its bank state. It brings the rank back out as soon as work arrives. When a refresh ends, the rank returns to the state it held before the refresh. A rank that was in precharge power-down goes on into self-refresh instead.

Every exit from a low-power state starts a wake-up timer. The command-ready output stays low until the timer expires, so the scheduler cannot issue a command early. The self-refresh exit latency is a separate, longer parameter than the power-down exit latency.

Top module: `rank_pwr_ctrl`

## Requirements
- R1: After reset the state is idle and cmd_ready is 1, with lp_enter and lp_exit at 0. The state is encoded as idle 0, refresh 1, self-refresh 2, precharge power-down 3, active 4 and active power-down 5.
- R2: From idle the rank moves to active when open_banks is nonzero. From active it moves back to idle when open_banks is zero. Each move takes one clock edge.
- R3: The rank enters a power-down state when all of these hold: pd_enable is 1, no operations are outstanding, both queues are empty, and no wake-up is pending. Idle enters precharge power-down and active enters active power-down. lp_enter pulses for exactly one cycle on entry.
- R4: While outstanding_ops is nonzero, no power-down entry happens.
- R5: While pd_enable is 0, no power-down entry happens.
- R6: Active power-down exits only to active, and precharge power-down exits to idle when any read or write is queued. lp_exit pulses for one cycle on every exit from a low-power state.
- R7: A refresh request in idle or precharge power-down moves the rank to refresh. The rank stays in refresh until ref_done. A refresh started from idle then returns to idle.
- R8: A refresh started from precharge power-down ends in self-refresh, and lp_enter pulses.
- R9: Self-refresh exits only to idle. It exits when any read is queued, or when a write is queued and bus_is_write is 1. A queued write while bus_is_write is 0 keeps the rank in self-refresh.
- R10: After an exit from power-down, cmd_ready stays 0 for PD_EXIT_CYC cycles. After an exit from self-refresh it stays 0 for SREF_EXIT_CYC cycles. It then returns to 1.
- R11: A refresh request while active has no effect, and the rank stays active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_enable | input | 1 | 1 allows power-down entry |
| open_banks | input | $clog2(BANKS+1) | Number of open banks in the rank |
| outstanding_ops | input | OPS_W | Activate/read/write operations still in flight |
| rd_queued | input | $clog2(QDEPTH+1) | Reads queued for this rank |
| wr_queued | input | $clog2(QDEPTH+1) | Writes queued for this rank |
| bus_is_write | input | 1 | Data bus currently in write mode |
| ref_req | input | 1 | Refresh controller asks to start a refresh |
| ref_done | input | 1 | Refresh controller reports the refresh complete |
| pwr_state | output | 3 | Current power state (encoding in R1) |
| lp_enter | output | 1 | One-cycle pulse on entry to a low-power state |
| lp_exit | output | 1 | One-cycle pulse on exit from a low-power state |
| cmd_ready | output | 1 | Rank awake and wake-up latency elapsed |

## Verification
The bench builds the block with PD_EXIT_CYC = 3 and SREF_EXIT_CYC = 9. These values are short enough that the whole cmd_ready low window can be walked cycle by cycle, and far enough apart that mixing up the two latencies shows at once. BANKS = 4, QDEPTH = 8 and OPS_W = 3 keep the count inputs narrow while still allowing nonzero occupancy on each of them. The refresh return path is taken once from idle and twice from precharge power-down, with one self-refresh exit forced by a read and one by a write while the bus is in write mode.

// File: rtl/rank_pwr_pkg.sv
package rank_pwr_pkg;

  typedef enum logic [2:0] {
    PS_IDLE = 3'd0,
    PS_REF  = 3'd1,
    PS_SREF = 3'd2,
    PS_PPD  = 3'd3,
    PS_ACT  = 3'd4,
    PS_APD  = 3'd5
  } pwr_state_e;

  function automatic logic is_low_power(pwr_state_e s);
    return (s == PS_SREF) || (s == PS_PPD) || (s == PS_APD);
  endfunction

endpackage

// File: rtl/rank_pwr_fsm.sv
module rank_pwr_fsm
  import rank_pwr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       banks_open,
  input  logic       lp_ok,
  input  logic       wake_req,
  input  logic       sref_force,
  input  logic       ref_req,
  input  logic       ref_done,
  output pwr_state_e state_q,
  output logic       exit_now,
  output logic       exit_from_sref,
  output logic       lp_enter_q,
  output logic       lp_exit_q
);

  pwr_state_e state_d;
  pwr_state_e prior_q;
  logic       prior_en;
  logic       enter_now;

  // next-state decision
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PS_IDLE: begin
        if (ref_req)         state_d = PS_REF;
        else if (banks_open) state_d = PS_ACT;
        else if (lp_ok)      state_d = PS_PPD;
      end
      PS_ACT: begin
        if (!banks_open)     state_d = PS_IDLE;
        else if (lp_ok)      state_d = PS_APD;
      end
      PS_APD: begin
        if (wake_req || ref_req) state_d = PS_ACT;
      end
      PS_PPD: begin
        if (ref_req)         state_d = PS_REF;
        else if (wake_req)   state_d = PS_IDLE;
      end
      PS_REF: begin
        if (ref_done)        state_d = (prior_q == PS_PPD) ? PS_SREF : PS_IDLE;
      end
      PS_SREF: begin
        if (sref_force)      state_d = PS_IDLE;
      end
      default:               state_d = PS_IDLE;
    endcase
  end

  assign enter_now      = !is_low_power(state_q) && is_low_power(state_d);
  assign exit_now       = is_low_power(state_q) && !is_low_power(state_d);
  assign exit_from_sref = exit_now && (state_q == PS_SREF);
  assign prior_en       = (state_q != PS_REF) && (state_d == PS_REF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= PS_IDLE;
      lp_enter_q <= 1'b0;
      lp_exit_q  <= 1'b0;
    end else begin
      state_q    <= state_d;
      lp_enter_q <= enter_now;
      lp_exit_q  <= exit_now;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prior_q <= PS_IDLE;
    end else if (prior_en) begin
      prior_q <= state_q;
    end
  end

  AST_APD_TO_ACT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_APD) |=> (state_q == PS_APD || state_q == PS_ACT)); // R6

  AST_SREF_TO_IDLE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_SREF) |=> (state_q == PS_SREF || state_q == PS_IDLE)); // R9

  AST_SREF_EXIT_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_q) == PS_SREF && state_q == PS_IDLE) |-> $past(sref_force)); // R9

  AST_REF_FROM_PPD_TO_SREF: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_REF && ref_done && prior_q == PS_PPD) |=> (state_q == PS_SREF)); // R8

  AST_ACT_IGNORES_REF: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_ACT) |=> (state_q != PS_REF)); // R11

endmodule

// File: rtl/rank_pwr_wake.sv
module rank_pwr_wake #(
  parameter int PD_EXIT_CYC   = 4,
  parameter int SREF_EXIT_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic load_sref,
  output logic timer_idle
);

  localparam int CNT_W = $clog2(SREF_EXIT_CYC + 1);
  localparam logic [CNT_W-1:0] PD_LOAD   = CNT_W'(PD_EXIT_CYC);
  localparam logic [CNT_W-1:0] SREF_LOAD = CNT_W'(SREF_EXIT_CYC);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_d = cnt_q;
    if (load)            cnt_d = load_sref ? SREF_LOAD : PD_LOAD;
    else if (cnt_q != 0) cnt_d = cnt_q - 1'b1;
  end

  assign cnt_en = load || (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign timer_idle = (cnt_q == '0);

  AST_LOAD_HOLDS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !timer_idle); // R10

endmodule

// File: rtl/rank_pwr_ctrl.sv
module rank_pwr_ctrl
  import rank_pwr_pkg::*;
#(
  parameter int BANKS         = 8,
  parameter int OPS_W         = 4,
  parameter int QDEPTH        = 32,
  parameter int PD_EXIT_CYC   = 4,
  parameter int SREF_EXIT_CYC = 16,
  localparam int BANK_W = $clog2(BANKS + 1),
  localparam int Q_W    = $clog2(QDEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pd_enable,
  input  logic [BANK_W-1:0] open_banks,
  input  logic [OPS_W-1:0]  outstanding_ops,
  input  logic [Q_W-1:0]    rd_queued,
  input  logic [Q_W-1:0]    wr_queued,
  input  logic              bus_is_write,
  input  logic              ref_req,
  input  logic              ref_done,
  output logic [2:0]        pwr_state,
  output logic              lp_enter,
  output logic              lp_exit,
  output logic              cmd_ready
);

  pwr_state_e state_q;
  logic       any_rd, any_wr, quiet, lp_ok, sref_force;
  logic       exit_now, exit_from_sref, timer_idle;

  assign any_rd     = (rd_queued != '0);
  assign any_wr     = (wr_queued != '0);
  assign quiet      = (outstanding_ops == '0) && !any_rd && !any_wr;
  assign lp_ok      = pd_enable && quiet && timer_idle;
  assign sref_force = any_rd || (any_wr && bus_is_write);

  rank_pwr_fsm u_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .banks_open     (open_banks != '0),
    .lp_ok          (lp_ok),
    .wake_req       (any_rd || any_wr),
    .sref_force     (sref_force),
    .ref_req        (ref_req),
    .ref_done       (ref_done),
    .state_q        (state_q),
    .exit_now       (exit_now),
    .exit_from_sref (exit_from_sref),
    .lp_enter_q     (lp_enter),
    .lp_exit_q      (lp_exit)
  );

  rank_pwr_wake #(
    .PD_EXIT_CYC   (PD_EXIT_CYC),
    .SREF_EXIT_CYC (SREF_EXIT_CYC)
  ) u_wake (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (exit_now),
    .load_sref  (exit_from_sref),
    .timer_idle (timer_idle)
  );

  assign pwr_state = state_q;
  assign cmd_ready = timer_idle && !is_low_power(state_q);

  AST_PD_ENTRY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state_q == PS_PPD || state_q == PS_APD) |-> ($past(outstanding_ops) == '0)); // R4

  AST_PD_ENTRY_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state_q == PS_PPD || state_q == PS_APD) |-> $past(pd_enable)); // R5

  AST_EXIT_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    lp_exit |-> !cmd_ready); // R10

  AST_PULSES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(lp_enter && lp_exit)); // R3

endmodule

// File: tb/rank_pwr_ctrl_tb.sv
module rank_pwr_ctrl_tb;

  localparam int BANKS = 4;
  localparam int OPS_W = 3;
  localparam int QDEPTH = 8;
  localparam int PD_N = 3;
  localparam int SR_N = 9;
  localparam int BANK_W = $clog2(BANKS + 1);
  localparam int Q_W = $clog2(QDEPTH + 1);

  localparam int S_IDLE = 0, S_REF = 1, S_SREF = 2, S_PPD = 3, S_ACT = 4, S_APD = 5;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              pd_enable;
  logic [BANK_W-1:0] open_banks;
  logic [OPS_W-1:0]  outstanding_ops;
  logic [Q_W-1:0]    rd_queued, wr_queued;
  logic              bus_is_write, ref_req, ref_done;
  logic [2:0]        pwr_state;
  logic              lp_enter, lp_exit, cmd_ready;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  rank_pwr_ctrl #(
    .BANKS(BANKS), .OPS_W(OPS_W), .QDEPTH(QDEPTH),
    .PD_EXIT_CYC(PD_N), .SREF_EXIT_CYC(SR_N)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .pd_enable(pd_enable), .open_banks(open_banks),
    .outstanding_ops(outstanding_ops), .rd_queued(rd_queued), .wr_queued(wr_queued),
    .bus_is_write(bus_is_write), .ref_req(ref_req), .ref_done(ref_done),
    .pwr_state(pwr_state), .lp_enter(lp_enter), .lp_exit(lp_exit), .cmd_ready(cmd_ready)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(int act, int exp, string req, string what);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_ready(int n, string req);
    for (int i = 1; i < n; i++) begin
      step();
      chk(int'(cmd_ready), 0, req, "cmd_ready during wake-up");
    end
    step();
    chk(int'(cmd_ready), 1, req, "cmd_ready after wake-up");
  endtask

  task automatic t_reset();
    chk(int'(pwr_state), S_IDLE, "R1", "state after reset");
    chk(int'(cmd_ready), 1, "R1", "cmd_ready after reset");
    chk(int'(lp_enter), 0, "R1", "lp_enter after reset");
    chk(int'(lp_exit), 0, "R1", "lp_exit after reset");
  endtask

  task automatic t_banks();
    open_banks = 2; step();
    chk(int'(pwr_state), S_ACT, "R2", "banks open");
    open_banks = 0; step();
    chk(int'(pwr_state), S_IDLE, "R2", "banks closed");
  endtask

  task automatic t_ppd_entry();
    pd_enable = 1; outstanding_ops = 2; step(); step();
    chk(int'(pwr_state), S_IDLE, "R4", "entry with ops outstanding");
    outstanding_ops = 0; step();
    chk(int'(pwr_state), S_PPD, "R3", "precharge power-down entry");
    chk(int'(lp_enter), 1, "R3", "lp_enter pulse");
    step();
    chk(int'(lp_enter), 0, "R3", "lp_enter one cycle");
  endtask

  task automatic t_ppd_exit();
    rd_queued = 1; step();
    chk(int'(pwr_state), S_IDLE, "R6", "ppd exit to idle");
    chk(int'(lp_exit), 1, "R6", "lp_exit pulse");
    chk(int'(cmd_ready), 0, "R10", "cmd_ready at ppd exit");
    wait_ready(PD_N, "R10");
    pd_enable = 0; rd_queued = 0; step(); step();
    chk(int'(pwr_state), S_IDLE, "R5", "entry with pd disabled");
  endtask

  task automatic t_apd();
    open_banks = 1; pd_enable = 1; step();
    chk(int'(pwr_state), S_ACT, "R2", "activate before apd");
    step();
    chk(int'(pwr_state), S_APD, "R3", "active power-down entry");
    wr_queued = 2; step();
    chk(int'(pwr_state), S_ACT, "R6", "apd exit to active");
    chk(int'(lp_exit), 1, "R6", "lp_exit from apd");
    wait_ready(PD_N, "R10");
    pd_enable = 0; wr_queued = 0; step();
    chk(int'(pwr_state), S_ACT, "R5", "active stays with pd disabled");
    open_banks = 0; step();
    chk(int'(pwr_state), S_IDLE, "R2", "back to idle");
  endtask

  task automatic t_ref_active();
    open_banks = 3; step();
    ref_req = 1; step(); step();
    chk(int'(pwr_state), S_ACT, "R11", "refresh request while active");
    ref_req = 0; open_banks = 0; step();
    chk(int'(pwr_state), S_IDLE, "R2", "idle after active");
  endtask

  task automatic t_ref_idle();
    ref_req = 1; step();
    chk(int'(pwr_state), S_REF, "R7", "refresh from idle");
    ref_req = 0; step(); step();
    chk(int'(pwr_state), S_REF, "R7", "refresh held until done");
    ref_done = 1; step();
    chk(int'(pwr_state), S_IDLE, "R7", "return to idle");
    ref_done = 0;
  endtask

  task automatic t_sref_write();
    pd_enable = 1; step();
    chk(int'(pwr_state), S_PPD, "R3", "ppd before refresh");
    ref_req = 1; step();
    chk(int'(pwr_state), S_REF, "R7", "refresh from ppd");
    ref_req = 0; ref_done = 1; step();
    chk(int'(pwr_state), S_SREF, "R8", "self-refresh after ppd refresh");
    chk(int'(lp_enter), 1, "R8", "lp_enter on self-refresh");
    ref_done = 0; wr_queued = 1; bus_is_write = 0; step(); step();
    chk(int'(pwr_state), S_SREF, "R9", "write queued, bus reading");
    chk(int'(cmd_ready), 0, "R10", "not ready in self-refresh");
    bus_is_write = 1; step();
    chk(int'(pwr_state), S_IDLE, "R9", "write queued, bus writing");
    chk(int'(lp_exit), 1, "R9", "lp_exit from self-refresh");
    wait_ready(SR_N, "R10");
    pd_enable = 0; wr_queued = 0; bus_is_write = 0; step();
  endtask

  task automatic t_sref_read();
    pd_enable = 1; step();
    ref_req = 1; step();
    ref_req = 0; ref_done = 1; step();
    chk(int'(pwr_state), S_SREF, "R8", "second self-refresh entry");
    ref_done = 0; pd_enable = 0; rd_queued = 4; step();
    chk(int'(pwr_state), S_IDLE, "R9", "read forces self-refresh exit");
    rd_queued = 0; step();
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
  endtask

  initial begin
    rst_n = 0; pd_enable = 0; open_banks = 0; outstanding_ops = 0;
    rd_queued = 0; wr_queued = 0; bus_is_write = 0; ref_req = 0; ref_done = 0;
    repeat (3) step();
    rst_n = 1;
    step();
    t_reset();
    t_banks();
    t_ppd_entry();
    t_ppd_exit();
    t_apd();
    t_ref_active();
    t_ref_idle();
    t_sref_write();
    t_sref_read();
    finished = 1;
    report();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
      $finish;
    end
  end

endmodule